// File: doc/BRIEF.md
# Write-and-Verify Block Command Engine

The engine takes one storage write command at a time. A ten-byte command block arrives as a byte stream and is decoded. The engine then accepts logical-block payload bytes from a host-side stream under a ready/valid handshake and stores them in an internal block store. The block store is organised as `NUM_BLKS` blocks of `BLK_BYTES` bytes each. Two options apply. With byte check, each stored block is read back and compared byte for byte with the bytes that were received. With replicate, a single received block is copied across a range of block addresses. A zero length has a meaning of its own in each mode.

The command ends with a one-cycle completion pulse that carries a status byte and a sense key. A second read port on the block store lets the surrounding logic read out what was written. A fault mask input XORs every byte on its way into the store. It stands in for a defective medium, so that the byte-check path can be driven to a miscompare.

Top module: `wv_engine`

## Requirements
- R1: A command whose first byte is not 2Eh ends with status 02h and sense key 5h. It accepts no payload and writes nothing.
- R2: In byte 1 of the command block, bit 1 is byte check and bit 2 is replicate. Bits 7:5, 4, 3 and 0 are ignored. Bytes 2..5 form the 32-bit start block, most significant byte first. Bytes 7..8 form the 16-bit length, most significant byte first. Bytes 6 and 9 are ignored.
- R3: With replicate clear and a length of zero, the command ends with status 00h and sense 0h, whatever the start block. It accepts no payload and writes nothing.
- R4: With replicate clear, exactly length × `BLK_BYTES` payload bytes are accepted. They are written to consecutive blocks beginning at the start block, in arrival order.
- R5: With replicate set and a nonzero length, exactly `BLK_BYTES` payload bytes are accepted, and that block is written to `length` consecutive blocks beginning at the start block.
- R6: With replicate set and a length of zero, the received block is written to every block from the start block through block `NUM_BLKS`-1.
- R7: A start block of `NUM_BLKS` or more, or a start plus length above `NUM_BLKS`, ends the command with status 02h and sense 5h before any payload is accepted. This applies to every command except the case covered by R3.
- R8: With byte check set, each block is read back after it is written. If any byte differs from the received byte, the command stops after that block with status 02h and sense key Eh. Otherwise it completes with status 00h and sense 0h.
- R9: With byte check clear, no read-back compare is made. The command completes with status 00h even when the stored bytes differ from the received ones.
- R10: `done` is high for exactly one cycle per command, while `busy` is low. `status` and `sense` change only together with `done` and hold their values until the next `done`.
- R11: After reset, `busy`, `done` and `data_ready` are 0, and `status` and `sense` are 0.
- R12: Each byte written is `payload ^ wr_corrupt`, stored at byte address block × `BLK_BYTES` + offset. `rd_data` returns the byte at `rd_addr` one cycle after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe, taken while idle |
| cmd_byte | input | 8 | Command block byte |
| data_valid | input | 1 | Payload byte valid |
| data_byte | input | 8 | Payload byte |
| data_ready | output | 1 | Engine accepts a payload byte this cycle |
| wr_corrupt | input | 8 | XOR mask applied to bytes entering the store |
| rd_addr | input | AW | Byte address for the readout port |
| rd_data | output | 8 | Readout byte, one cycle latency |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Completion status (00h good, 02h check condition) |
| sense | output | 4 | Sense key (0h none, 5h illegal request, Eh miscompare) |

## Verification
The bench pairs a zero length with each mode. A design that shares the zero case between modes would either write a replicated block nowhere or stall waiting for payload. The bench also drives start addresses just inside and just past the end of the store, and sets bits only in the high bytes of the address and length fields. A design with a wrong range check or wrong byte order would then write into the store instead of rejecting the command. Corrupting masks are applied with byte check on and off, so that a design that compares the wrong bytes, skips the read-back, or does not stop after the failing block shows up in the status, the count of accepted bytes or the store contents.

// File: rtl/wv_pkg.sv
package wv_pkg;
  localparam logic [7:0] OPC_WRITE_VERIFY = 8'h2E;
  localparam logic [7:0] ST_GOOD          = 8'h00;
  localparam logic [7:0] ST_CHECK         = 8'h02;
  localparam logic [3:0] SK_NONE          = 4'h0;
  localparam logic [3:0] SK_ILLEGAL       = 4'h5;
  localparam logic [3:0] SK_MISCOMPARE    = 4'hE;

  typedef struct packed {
    logic        opc_ok;
    logic        bytchk;
    logic        replicate;
    logic [31:0] start_blk;
    logic [15:0] num_blks;
  } cmd_fields_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RECV, S_WRITE, S_VERIFY, S_NEXT, S_FINISH
  } eng_state_t;
endpackage

// File: rtl/wv_cdb_capture.sv
module wv_cdb_capture
  import wv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  output cmd_fields_t fields,
  output logic        fields_done
);
  localparam logic [3:0] LAST_IDX = 4'd9;
  logic [3:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx         <= '0;
      fields      <= '0;
      fields_done <= 1'b0;
    end else begin
      fields_done <= 1'b0;
      if (en && byte_valid) begin
        case (idx)
          4'd0: fields.opc_ok <= (byte_in == OPC_WRITE_VERIFY);
          4'd1: begin
            fields.bytchk    <= byte_in[1];
            fields.replicate <= byte_in[2];
          end
          4'd2: fields.start_blk[31:24] <= byte_in;
          4'd3: fields.start_blk[23:16] <= byte_in;
          4'd4: fields.start_blk[15:8]  <= byte_in;
          4'd5: fields.start_blk[7:0]   <= byte_in;
          4'd7: fields.num_blks[15:8]   <= byte_in;
          4'd8: fields.num_blks[7:0]    <= byte_in;
          default: ;
        endcase
        if (idx == LAST_IDX) begin
          idx         <= '0;
          fields_done <= 1'b1;
        end else begin
          idx <= idx + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/wv_block_store.sv
module wv_block_store #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/wv_engine.sv
module wv_engine
  import wv_pkg::*;
#(
  parameter  int BLK_BYTES = 4,
  parameter  int NUM_BLKS  = 16,
  localparam int AW        = $clog2(BLK_BYTES) + $clog2(NUM_BLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic          data_valid,
  input  logic [7:0]    data_byte,
  output logic          data_ready,
  input  logic [7:0]    wr_corrupt,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic [7:0]    status,
  output logic [3:0]    sense
);
  localparam int BW    = $clog2(BLK_BYTES);
  localparam int NBW   = $clog2(NUM_BLKS);
  localparam int CW    = NBW + 1;
  localparam int DEPTH = BLK_BYTES * NUM_BLKS;
  localparam logic [BW:0] LAST_B = (BW+1)'(BLK_BYTES - 1);
  localparam logic [BW:0] FULL_B = (BW+1)'(BLK_BYTES);

  eng_state_t    state;
  cmd_fields_t   fields;
  logic          fields_done;
  logic [BW:0]   byte_idx;
  logic [NBW-1:0] blk_cur;
  logic [CW-1:0] blks_left;
  logic          bytchk_q, repl_q, mis_acc;
  logic [7:0]    res_st;
  logic [3:0]    res_sk;
  logic [7:0]    blk_buf [BLK_BYTES];
  logic          chk_v;
  logic [BW-1:0] chk_i;
  logic          a_we;
  logic [AW-1:0] a_addr;
  logic [7:0]    a_wdata, a_rdata;
  logic          cmp_bad;

  wv_cdb_capture u_cap (
    .clk(clk), .rst(rst), .en(state == S_IDLE), .byte_valid(cmd_valid),
    .byte_in(cmd_byte), .fields(fields), .fields_done(fields_done)
  );

  wv_block_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .b_addr(rd_addr), .b_rdata(rd_data)
  );

  // range evaluation of the decoded command
  logic [32:0]   end_sum;
  logic          start_in, span_fits, zero_fill;
  logic [CW-1:0] fill_cnt;
  always_comb begin
    end_sum   = {1'b0, fields.start_blk} + 33'(fields.num_blks);
    start_in  = fields.start_blk < 32'(NUM_BLKS);
    span_fits = end_sum <= 33'(NUM_BLKS);
    zero_fill = fields.replicate && (fields.num_blks == 16'd0);
    fill_cnt  = CW'(NUM_BLKS) - {1'b0, fields.start_blk[NBW-1:0]};
  end

  assign a_we       = (state == S_WRITE);
  assign a_addr     = {blk_cur, byte_idx[BW-1:0]};
  assign a_wdata    = blk_buf[byte_idx[BW-1:0]] ^ wr_corrupt;
  assign cmp_bad    = chk_v && (a_rdata != blk_buf[chk_i]);
  assign data_ready = (state == S_RECV);
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (state == S_RECV && data_valid) blk_buf[byte_idx[BW-1:0]] <= data_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_v <= 1'b0;
      chk_i <= '0;
    end else begin
      chk_v <= (state == S_VERIFY) && (byte_idx < FULL_B);
      chk_i <= byte_idx[BW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      byte_idx  <= '0;
      blk_cur   <= '0;
      blks_left <= '0;
      bytchk_q  <= 1'b0;
      repl_q    <= 1'b0;
      mis_acc   <= 1'b0;
      res_st    <= ST_GOOD;
      res_sk    <= SK_NONE;
      done      <= 1'b0;
      status    <= ST_GOOD;
      sense     <= SK_NONE;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (fields_done) state <= S_CHECK;
        S_CHECK: begin
          byte_idx <= '0;
          blk_cur  <= fields.start_blk[NBW-1:0];
          bytchk_q <= fields.bytchk;
          repl_q   <= fields.replicate;
          state    <= S_FINISH;
          if (!fields.opc_ok) begin
            res_st <= ST_CHECK; res_sk <= SK_ILLEGAL;
          end else if (!fields.replicate && fields.num_blks == 16'd0) begin
            res_st <= ST_GOOD;  res_sk <= SK_NONE;
          end else if (!start_in || (!zero_fill && !span_fits)) begin
            res_st <= ST_CHECK; res_sk <= SK_ILLEGAL;
          end else begin
            blks_left <= zero_fill ? fill_cnt : fields.num_blks[CW-1:0];
            state     <= S_RECV;
          end
        end
        S_RECV: if (data_valid) begin
          if (byte_idx == LAST_B) begin
            byte_idx <= '0;
            state    <= S_WRITE;
          end else byte_idx <= byte_idx + 1'b1;
        end
        S_WRITE: begin
          if (byte_idx == LAST_B) begin
            byte_idx <= '0;
            mis_acc  <= 1'b0;
            state    <= bytchk_q ? S_VERIFY : S_NEXT;
          end else byte_idx <= byte_idx + 1'b1;
        end
        S_VERIFY: begin
          mis_acc <= mis_acc | cmp_bad;
          if (byte_idx == FULL_B) begin
            byte_idx <= '0;
            if (mis_acc | cmp_bad) begin
              res_st <= ST_CHECK; res_sk <= SK_MISCOMPARE;
              state  <= S_FINISH;
            end else state <= S_NEXT;
          end else byte_idx <= byte_idx + 1'b1;
        end
        S_NEXT: begin
          blks_left <= blks_left - 1'b1;
          blk_cur   <= blk_cur + 1'b1;
          if (blks_left == CW'(1)) begin
            res_st <= ST_GOOD; res_sk <= SK_NONE;
            state  <= S_FINISH;
          end else state <= repl_q ? S_WRITE : S_RECV;
        end
        S_FINISH: begin
          done   <= 1'b1;
          status <= res_st;
          sense  <= res_sk;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wv_engine_chk.sv
module wv_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       data_ready,
  input logic [7:0] status,
  input logic [3:0] sense,
  input logic       st_we
);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(status) && $stable(sense)));

  assert_ready_in_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> busy);

  assert_no_write_during_rx_R5: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (!data_ready && busy));

  assert_legal_result_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ((status == 8'h00 && sense == 4'h0) ||
              (status == 8'h02 && (sense == 4'h5 || sense == 4'hE))));
endmodule

bind wv_engine wv_engine_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .data_ready(data_ready),
  .status(status), .sense(sense), .st_we(a_we)
);

// File: tb/sim_wv_engine.sv
module sim_wv_engine;
  localparam int BB = 4;
  localparam int NB = 16;
  localparam int AW = 6;
  localparam int MB = BB * NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [7:0]    cmd_byte = '0;
  logic          data_valid = 1'b0;
  logic [7:0]    data_byte = '0;
  logic          data_ready;
  logic [7:0]    wr_corrupt = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy, done;
  logic [7:0]    status;
  logic [3:0]    sense;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [MB];
  logic [7:0] src [MB];

  always #2 clk = ~clk;

  wv_engine #(.BLK_BYTES(BB), .NUM_BLKS(NB)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_valid(data_valid), .data_byte(data_byte), .data_ready(data_ready),
    .wr_corrupt(wr_corrupt), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .status(status), .sense(sense)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected outcome from the requirements; updates the store model.
  function automatic void predict(input logic [7:0] op, input bit bc, input bit ws,
                                  input logic [31:0] lba, input logic [15:0] len,
                                  input logic [7:0] cm, output logic [7:0] st,
                                  output logic [3:0] sk, output int nbytes);
    int cnt;
    st = 8'h00; sk = 4'h0; nbytes = 0;
    if (op != 8'h2E) begin st = 8'h02; sk = 4'h5; return; end
    if (!ws && len == 16'd0) return;
    if (lba >= 32'(NB)) begin st = 8'h02; sk = 4'h5; return; end
    if (ws && len == 16'd0) cnt = NB - int'(lba[7:0]);
    else begin
      if (longint'(lba) + longint'(len) > longint'(NB)) begin
        st = 8'h02; sk = 4'h5; return;
      end
      cnt = int'(len);
    end
    nbytes = ws ? BB : cnt * BB;
    for (int b = 0; b < cnt; b++) begin
      for (int i = 0; i < BB; i++)
        model[(int'(lba[7:0]) + b) * BB + i] = src[(ws ? 0 : b) * BB + i] ^ cm;
      if (bc && cm != 8'h00) begin st = 8'h02; sk = 4'hE; nbytes = BB; return; end
    end
  endfunction

  task automatic dump_check(input string req);
    int mism = 0;
    logic [7:0] got;
    @(negedge clk) rd_addr = '0;
    for (int a = 0; a < MB; a++) begin
      @(negedge clk);
      got = rd_data;
      if (got !== model[a]) mism++;
      rd_addr = AW'(a + 1);
    end
    check(mism == 0, {"R12 ", req}, "store bytes mismatching", mism, 0);
  endtask

  task automatic run(input logic [7:0] op, input bit bc, input bit ws,
                     input logic [31:0] lba, input logic [15:0] len,
                     input logic [7:0] cm, input string req);
    logic [7:0] cb [10];
    logic [7:0] est; logic [3:0] esk; int ebytes;
    int k = 0; int n = 0; bit seen = 0;
    logic [7:0] gst; logic [3:0] gsk;
    for (int i = 0; i < MB; i++) src[i] = 8'($urandom);
    predict(op, bc, ws, lba, len, cm, est, esk, ebytes);
    cb[0] = op;
    cb[1] = {3'($urandom), 2'($urandom), ws, bc, 1'($urandom)};
    cb[2] = lba[31:24]; cb[3] = lba[23:16]; cb[4] = lba[15:8]; cb[5] = lba[7:0];
    cb[6] = 8'($urandom);
    cb[7] = len[15:8]; cb[8] = len[7:0];
    cb[9] = 8'($urandom);
    wr_corrupt = cm;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); cmd_valid = 1'b1; cmd_byte = cb[i];
    end
    @(negedge clk); cmd_valid = 1'b0;
    while (!seen && n < 4000) begin
      if (done) begin
        seen = 1; gst = status; gsk = sense; data_valid = 1'b0;
      end else begin
        if (data_ready && k < MB) begin
          data_valid = 1'b1; data_byte = src[k]; k++;
        end else data_valid = 1'b0;
        @(negedge clk);
        n++;
      end
    end
    check(seen, req, "completion seen", seen, 1);
    if (!seen) return;
    check(gst == est, req, "status", gst, est);
    check(gsk == esk, req, "sense", gsk, esk);
    check(k == ebytes, req, "payload bytes accepted", k, ebytes);
    @(negedge clk);
    check(!done && status == gst && sense == gsk, "R10", "pulse ends, result held",
          {done, status, sense}, {1'b0, gst, gsk});
    dump_check(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !data_ready && status == 8'h00 && sense == 4'h0,
          "R11", "reset outputs", {busy, done, data_ready, status, sense}, 0);
    run(8'h2E, 0, 1, 32'd0,  16'd0,  8'h00, "R6");  // fill whole store
    run(8'h2E, 0, 0, 32'd0,  16'd16, 8'h00, "R4");
    run(8'h2A, 0, 0, 32'd1,  16'd2,  8'h00, "R1");
    run(8'h2E, 1, 0, 32'd3,  16'd0,  8'h00, "R3");
    run(8'h2E, 0, 0, 32'd1000, 16'd0, 8'h00, "R3");
    run(8'h2E, 0, 0, 32'd2,  16'd3,  8'h00, "R4");
    run(8'h2E, 0, 1, 32'd5,  16'd4,  8'h00, "R5");
    run(8'h2E, 0, 1, 32'd12, 16'd0,  8'h00, "R6");
    run(8'h2E, 0, 0, 32'd14, 16'd3,  8'h00, "R7");
    run(8'h2E, 0, 0, 32'h0100_0000, 16'd1, 8'h00, "R7");
    run(8'h2E, 0, 1, 32'd16, 16'd0,  8'h00, "R7");
    run(8'h2E, 0, 0, 32'd15, 16'd1,  8'h00, "R7");
    run(8'h2E, 0, 0, 32'd0,  16'h0100, 8'h00, "R2");
    run(8'h2E, 1, 0, 32'd7,  16'd2,  8'h00, "R8");
    run(8'h2E, 1, 0, 32'd9,  16'd3,  8'h10, "R8");
    run(8'h2E, 1, 1, 32'd10, 16'd3,  8'h01, "R8");
    run(8'h2E, 0, 0, 32'd1,  16'd2,  8'h81, "R9");
    run(8'h2E, 0, 1, 32'd3,  16'd2,  8'h42, "R9");
    for (int t = 0; t < 40; t++) begin
      logic [7:0] op = ($urandom % 8 == 0) ? 8'($urandom) : 8'h2E;
      logic [7:0] cm = ($urandom % 4 == 0) ? (8'($urandom) | 8'h01) : 8'h00;
      logic [15:0] ln = ($urandom % 10 == 0) ? 16'h0101 : 16'($urandom % 6);
      run(op, 1'($urandom), 1'($urandom), 32'($urandom % 20), ln, cm, "R2");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule